// File: doc/BRIEF.md
# Serial Ratio and Mode Configuration Port

This block is the configuration front end of a frequency synthesizer's divider chain. Software drives three wires: a serial clock, a data line and an enable. While enable is high the block shifts in one fixed-length word. When enable drops, it looks at the top bits of the word, which form an address, and routes the rest of the word to one of four destinations. These are the reference divide ratio, the main and swallow divide ratios (one word), and two mode words. The mode words set the dual-modulus enable, the ratio-loading discipline, the anti-dead-zone pulse width, the pump current setting, the detector polarity, the modulus-control edge, two standby controls and two general-purpose outputs.

The divide ratios are staged. The divider chain reads the staged values when a one-cycle load strobe fires. In immediate mode a ratio write fires the strobe at once. In aligned mode the write only marks a pending transfer. The strobe then waits for the divider chain to report its terminal count, so the new ratios take effect on a cycle boundary and the detector keeps its phase state. The loading mode is held in the second mode word, so software writes that word before it writes any ratio.

The serial lines are treated as asynchronous. They are resynchronized to the system clock and edge-detected there, and every register in the block runs on the system clock.

Top module: `cfg_serial_port`

## Requirements
- R1: After synchronous reset the staged ratios are zero, single-modulus mode and immediate loading are selected, anti-dead-zone width code is 0 (shortest), pump code, polarity and edge bits are 0, both standby controls and both general outputs are low, and neither the load strobe nor the pending flag is set.
- R2: A word is 24 bits, sampled on rising serial clock while enable is high, most significant bit first. It is committed when enable falls. The address is bits [23:21]. Address 0 writes bits [13:0] to the reference ratio.
- R3: Address 1 writes bits [17:7] to the main ratio and bits [6:0] to the swallow ratio.
- R4: Address 2 writes the first mode word: bits [1:0] anti-dead-zone width, bits [4:2] pump current code, bit 5 detector inversion, bit 6 modulus-control falling-edge select.
- R5: Address 3 writes the second mode word: bit 0 dual-modulus enable, bit 1 aligned loading, bit 2 standby 1, bit 3 standby 2, bit 4 general output 1, bit 5 general output 2.
- R6: A word with a bit count other than 24 is discarded, and no register or strobe changes.
- R7: A word with address 4 to 7 is discarded, and no register or strobe changes.
- R8: With immediate loading, each ratio write (address 0 or 1) gives exactly one load strobe pulse of one cycle, and the pending flag stays low. Mode word writes give no strobe.
- R9: With aligned loading, a ratio write sets the pending flag and gives no strobe. The flag holds until the divider terminal-count input is seen high. Then exactly one strobe fires and the flag clears. Terminal count with no pending transfer gives no strobe.
- R10: In single-modulus mode the swallow ratio output reads 0. The staged swallow value is kept and shows again when dual-modulus mode is selected.
- R11: Serial clock edges while enable is low shift nothing and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Word framing enable, high during a word |
| div_tc | input | 1 | Divider terminal count, one cycle |
| ref_ratio | output | 14 | Staged reference divide ratio |
| main_ratio | output | 11 | Staged main divide ratio |
| swallow_ratio | output | 7 | Staged swallow ratio, 0 in single mode |
| ratio_load | output | 1 | One-cycle strobe to take staged ratios |
| ratio_pending | output | 1 | Aligned transfer waiting for terminal count |
| dual_mode | output | 1 | Dual-modulus operation selected |
| sync_load | output | 1 | Aligned ratio loading selected |
| ab_width | output | 2 | Anti-dead-zone pulse width code |
| cp_current | output | 3 | Pump current code |
| pd_invert | output | 1 | Detector output inverted |
| mod_fall_edge | output | 1 | Modulus control on falling edge |
| standby1 | output | 1 | Standby control 1 |
| standby2 | output | 1 | Standby control 2 |
| mfo1 | output | 1 | General output 1 |
| mfo2 | output | 1 | General output 2 |

## Verification
The vector table sends words of the correct length to each ratio address, including all-ones payloads. These show whether the field positions and the MSB-first order are right. Words that are one bit short, one bit long, or carry an unused address must leave every output and the strobe count unchanged, which separates the length check from the address check. Directed sequences write the mode words with distinct bit patterns, then run the aligned loading handshake with a wait before the terminal count and a spare terminal count after it. They also switch single/dual mode to show the swallow masking, and clock the serial line with enable low.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int ADR_REF = 0;
  localparam int ADR_DIV = 1;
  localparam int ADR_ST1 = 2;
  localparam int ADR_ST2 = 3;

  // first mode word, bit 0 at the bottom
  typedef struct packed {
    logic       mod_fall_edge; // [6]
    logic       pd_invert;     // [5]
    logic [2:0] cp_current;    // [4:2]
    logic [1:0] ab_width;      // [1:0]
  } st1_t;

  // second mode word
  typedef struct packed {
    logic mfo2;      // [5]
    logic mfo1;      // [4]
    logic standby2;  // [3]
    logic standby1;  // [2]
    logic sync_load; // [1]
    logic dual_mode; // [0]
  } st2_t;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_prev <= '0;
    else     q_prev <= stg[STAGES-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift_rx.sv
module cfg_shift_rx #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sdi,
  input  logic              en,
  input  logic              en_fall,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_MAX = WORD_W + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= en_fall && (cnt == CNT_W'(WORD_W));
      if (!en) begin
        cnt <= '0;
      end else if (sck_rise) begin
        word <= {word[WORD_W-2:0], sdi};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_serial_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3,
  parameter int REF_W  = 14,
  parameter int MAIN_W = 11,
  parameter int SWL_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word,
  input  logic              div_tc,
  output logic [REF_W-1:0]  ref_q,
  output logic [MAIN_W-1:0] main_q,
  output logic [SWL_W-1:0]  swl_q,
  output st1_t              st1_q,
  output st2_t              st2_q,
  output logic              load_q,
  output logic              pend_q
);
  localparam int PAY_W = WORD_W - ADDR_W;
  localparam int S1_W  = $bits(st1_t);
  localparam int S2_W  = $bits(st2_t);

  logic [ADDR_W-1:0] addr;
  logic [PAY_W-1:0]  pay;
  logic              hit_ref, hit_div, hit_s1, hit_s2, ratio_wr;

  assign addr     = word[WORD_W-1 -: ADDR_W];
  assign pay      = word[PAY_W-1:0];
  assign hit_ref  = word_vld && (addr == ADDR_W'(ADR_REF));
  assign hit_div  = word_vld && (addr == ADDR_W'(ADR_DIV));
  assign hit_s1   = word_vld && (addr == ADDR_W'(ADR_ST1));
  assign hit_s2   = word_vld && (addr == ADDR_W'(ADR_ST2));
  assign ratio_wr = hit_ref || hit_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      main_q <= '0;
      swl_q  <= '0;
      st1_q  <= '0;
      st2_q  <= '0;
      load_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (hit_ref) ref_q <= pay[REF_W-1:0];
      if (hit_div) begin
        main_q <= pay[SWL_W +: MAIN_W];
        swl_q  <= pay[SWL_W-1:0];
      end
      if (hit_s1) st1_q <= st1_t'(pay[S1_W-1:0]);
      if (hit_s2) st2_q <= st2_t'(pay[S2_W-1:0]);
      load_q <= (ratio_wr && !st2_q.sync_load) || (pend_q && div_tc);
      if (ratio_wr && st2_q.sync_load) pend_q <= 1'b1;
      else if (div_tc)                 pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3,
  parameter int REF_W  = 14,
  parameter int MAIN_W = 11,
  parameter int SWL_W  = 7,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  input  logic              div_tc,
  output logic [REF_W-1:0]  ref_ratio,
  output logic [MAIN_W-1:0] main_ratio,
  output logic [SWL_W-1:0]  swallow_ratio,
  output logic              ratio_load,
  output logic              ratio_pending,
  output logic              dual_mode,
  output logic              sync_load,
  output logic [1:0]        ab_width,
  output logic [2:0]        cp_current,
  output logic              pd_invert,
  output logic              mod_fall_edge,
  output logic              standby1,
  output logic              standby2,
  output logic              mfo1,
  output logic              mfo2
);
  logic [2:0]        sy, sy_prev;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  logic [SWL_W-1:0]  swl_q;
  st1_t              st1;
  st2_t              st2;

  cfg_sync_edge #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst),
    .d({ser_en, ser_data, ser_clk}),
    .q(sy), .q_prev(sy_prev)
  );

  cfg_shift_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst),
    .sck_rise(sy[0] && !sy_prev[0]),
    .sdi(sy[1]),
    .en(sy[2]),
    .en_fall(!sy[2] && sy_prev[2]),
    .word_vld(word_vld), .word(word)
  );

  cfg_reg_bank #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .REF_W(REF_W),
    .MAIN_W(MAIN_W), .SWL_W(SWL_W)
  ) u_bank (
    .clk(clk), .rst(rst),
    .word_vld(word_vld), .word(word), .div_tc(div_tc),
    .ref_q(ref_ratio), .main_q(main_ratio), .swl_q(swl_q),
    .st1_q(st1), .st2_q(st2),
    .load_q(ratio_load), .pend_q(ratio_pending)
  );

  assign swallow_ratio = st2.dual_mode ? swl_q : '0;
  assign dual_mode     = st2.dual_mode;
  assign sync_load     = st2.sync_load;
  assign standby1      = st2.standby1;
  assign standby2      = st2.standby2;
  assign mfo1          = st2.mfo1;
  assign mfo2          = st2.mfo2;
  assign ab_width      = st1.ab_width;
  assign cp_current    = st1.cp_current;
  assign pd_invert     = st1.pd_invert;
  assign mod_fall_edge = st1.mod_fall_edge;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk (
  input logic clk,
  input logic rst,
  input logic div_tc,
  input logic ratio_load,
  input logic ratio_pending,
  input logic sync_load
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ratio_load && !ratio_pending));

  // R8
  load_single_chk: assert property (@(posedge clk) disable iff (rst)
    ratio_load |=> !ratio_load);

  // R8
  pend_sync_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ratio_pending) |-> sync_load);

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_pending && !div_tc) |=> ratio_pending);

  // R9
  pend_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_pending && div_tc) |=> ratio_load);
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
  .clk(clk), .rst(rst), .div_tc(div_tc), .ratio_load(ratio_load),
  .ratio_pending(ratio_pending), .sync_load(sync_load)
);

// File: tb/cfg_serial_port_bench.sv
module cfg_serial_port_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0, div_tc = 1'b0;
  logic [13:0] ref_ratio;
  logic [10:0] main_ratio;
  logic [6:0]  swallow_ratio;
  logic ratio_load, ratio_pending, dual_mode, sync_load;
  logic [1:0] ab_width;
  logic [2:0] cp_current;
  logic pd_invert, mod_fall_edge, standby1, standby2, mfo1, mfo2;

  int tests = 0, fails = 0, loads = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_serial_port u_cfg_serial_port (.*);

  always @(negedge clk) if (!rst && ratio_load) loads++;

  // {nbits[6], word[24], ref[14], main[11], swallow[7], strobes[2]}
  localparam logic [63:0] VEC [9] = '{
    {6'd24, 24'h600001, 14'd0,     11'd0,    7'd0,   2'd0},
    {6'd24, 24'h000064, 14'd100,   11'd0,    7'd0,   2'd1},
    {6'd24, 24'h20FA11, 14'd100,   11'd500,  7'd17,  2'd1},
    {6'd23, 24'h000055, 14'd100,   11'd500,  7'd17,  2'd0},
    {6'd25, 24'h000033, 14'd100,   11'd500,  7'd17,  2'd0},
    {6'd24, 24'hA00077, 14'd100,   11'd500,  7'd17,  2'd0},
    {6'd24, 24'hE00001, 14'd100,   11'd500,  7'd17,  2'd0},
    {6'd24, 24'h003FFF, 14'd16383, 11'd500,  7'd17,  2'd1},
    {6'd24, 24'h23FFFF, 14'd16383, 11'd2047, 7'd127, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [23:0] w);
    ser_en = 1'b1;
    wait_clk(3);
    for (int i = 0; i < nbits; i++) begin
      ser_data = (i < 24) ? w[23-i] : 1'b0;
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(3);
      ser_clk = 1'b0;
    end
    wait_clk(3);
    ser_en = 1'b0;
    wait_clk(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    chk("R1 ref", ref_ratio, 0);
    chk("R1 main", main_ratio, 0);
    chk("R1 dual", dual_mode, 0);
    chk("R1 sync", sync_load, 0);
    chk("R1 ab", ab_width, 0);
    chk("R1 stby", {standby1, standby2, mfo1, mfo2}, 0);
    chk("R1 strobe/pend", {ratio_load, ratio_pending}, 0);

    for (int k = 0; k < 9; k++) begin
      base = loads;
      send(int'(VEC[k][63:58]), VEC[k][57:34]);
      chk($sformatf("R2 R6 R7 ref vec%0d", k), ref_ratio, VEC[k][33:20]);
      chk($sformatf("R3 R6 R7 main vec%0d", k), main_ratio, VEC[k][19:9]);
      chk($sformatf("R3 R6 R7 swallow vec%0d", k), swallow_ratio, VEC[k][8:2]);
      chk($sformatf("R8 strobes vec%0d", k), loads - base, VEC[k][1:0]);
      chk($sformatf("R8 pending vec%0d", k), ratio_pending, 0);
    end

    // R4 first mode word
    base = loads;
    send(24, 24'h400076);
    chk("R4 ab_width", ab_width, 2);
    chk("R4 cp_current", cp_current, 5);
    chk("R4 invert/edge", {pd_invert, mod_fall_edge}, 2'b11);
    chk("R8 mode word no strobe", loads - base, 0);

    // R5 second mode word, all bits set
    send(24, 24'h60003F);
    chk("R5 dual/sync", {dual_mode, sync_load}, 2'b11);
    chk("R5 standby", {standby1, standby2}, 2'b11);
    chk("R5 outputs", {mfo1, mfo2}, 2'b11);
    chk("R4 kept", {ab_width, cp_current}, {2'd2, 3'd5});

    // R9 aligned loading
    base = loads;
    send(24, 24'h000007);
    chk("R9 staged ref", ref_ratio, 7);
    chk("R9 pending set", ratio_pending, 1);
    chk("R9 no early strobe", loads - base, 0);
    wait_clk(20);
    chk("R9 pending held", ratio_pending, 1);
    div_tc = 1'b1;
    wait_clk(1);
    div_tc = 1'b0;
    wait_clk(3);
    chk("R9 one strobe on tc", loads - base, 1);
    chk("R9 pending cleared", ratio_pending, 0);
    div_tc = 1'b1;
    wait_clk(1);
    div_tc = 1'b0;
    wait_clk(3);
    chk("R9 idle tc no strobe", loads - base, 1);

    // R10 single mode masks swallow
    send(24, 24'h600000);
    chk("R10 swallow masked", swallow_ratio, 0);
    chk("R10 main unaffected", main_ratio, 2047);
    send(24, 24'h600001);
    chk("R10 swallow restored", swallow_ratio, 127);

    // R11 serial clocks with enable low
    base = loads;
    ser_data = 1'b1;
    for (int i = 0; i < 24; i++) begin
      wait_clk(3);
      ser_clk = 1'b1;
      wait_clk(3);
      ser_clk = 1'b0;
    end
    ser_data = 1'b0;
    wait_clk(10);
    chk("R11 ref kept", ref_ratio, 7);
    chk("R11 main kept", main_ratio, 2047);
    chk("R11 mode kept", {dual_mode, sync_load, ab_width}, {1'b1, 1'b0, 2'd2});
    chk("R11 no strobe", loads - base, 0);

    // R2 word after stray clocks still lands
    send(24, 24'h000123);
    chk("R2 ref after stray clocks", ref_ratio, 14'h123);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule